// File: doc/BRIEF.md
# Ethernet Receive Frame Classifier

This block sits between a receive MAC and a bank of statistics counters. Each received frame produces one end-of-frame event. The event carries the frame length in bytes (counting the FCS, but not the preamble or SFD), an FCS error flag, the destination cast type and flags for control, pause and priority flow control (PFC) frames. The block turns that event into a set of one-cycle increment strobes, one for each counter the frame should advance. A separate start-of-frame input produces a frame-start strobe.

A configured maximum frame size bounds the top size bucket. Frames longer than that maximum go to the oversize counter instead of a size bucket. Frames shorter than 64 bytes go to no size bucket. The fragment, jabber and legal-length CRC-error strobes split frames with a bad FCS by length. The runt strobe skips frames of eight bytes or fewer, because those are treated as decoding errors. All strobes for one frame rise together in a single cycle, one clock after the event. This lets every counter in the bank update in the same cycle.

Top module: `rx_frame_classifier`

## Requirements
- R1: `startStrb` is high in the cycle after each cycle with `sofValid` high, whatever the other inputs are, and low otherwise.
- R2: Every strobe except `startStrb` is high only in the cycle after a cycle with `eofValid` high. All of them are low after reset and after cycles without an end-of-frame event.
- R3: `sizeStrb` has at most one bit set. The length includes the FCS. Bit 0 is exactly 64 bytes, bit 1 is 65–127, bit 2 is 128–255, bit 3 is 256–511, bit 4 is 512–1023 and bit 5 is 1024–1518. A frame shorter than 64 bytes sets no bit.
- R4: Bit 6 of `sizeStrb` covers 1519 bytes up to and including `maxLen`. A frame longer than `maxLen` raises `oversizeStrb` and sets no size bit, even when `maxLen` is below 1518.
- R5: `fragStrb` rises for a frame shorter than 64 bytes with `fcsErr` set.
- R6: `jabberStrb` rises for a frame longer than `maxLen` with `fcsErr` set.
- R7: `crcLegalStrb` rises for a frame of 64 bytes or more with `fcsErr` set, oversized frames included.
- R8: `runtStrb` rises for a frame of 9 to 63 bytes, whatever its FCS status. A frame of 8 bytes or fewer gives no runt strobe.
- R9: `castType` is encoded as 0 unicast, 1 multicast, 2 broadcast and 3 none. Bit n of the data strobes is cast n. A frame with `isCtrl` low raises `dataOkStrb` when its FCS is good and `dataErrStrb` when `fcsErr` is set. Cast 3 raises neither.
- R10: A frame with `isCtrl` high raises `ctrlOkStrb` or `ctrlErrStrb` at its cast bit, chosen by `fcsErr`, and never a data strobe.
- R11: `pauseStrb` rises for every frame with `isPause` set. `pauseErrStrb` rises only when `fcsErr` is also set.
- R12: A frame with `isPfc` set raises `pfcOkStrb` when its FCS is good and `pfcErrStrb` when `fcsErr` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| sofValid | input | 1 | Start-of-frame event |
| eofValid | input | 1 | End-of-frame event; the inputs below are valid with it |
| frameLen | input | LEN_W | Frame length in bytes, FCS included |
| fcsErr | input | 1 | Frame had an FCS error |
| maxLen | input | LEN_W | Configured maximum frame size in bytes |
| castType | input | 2 | 0 unicast, 1 multicast, 2 broadcast, 3 none |
| isCtrl | input | 1 | Control frame |
| isPause | input | 1 | Pause frame |
| isPfc | input | 1 | Priority flow control frame |
| startStrb | output | 1 | Frame-start increment |
| sizeStrb | output | 7 | Size bucket increments |
| oversizeStrb | output | 1 | Frame above maxLen |
| fragStrb | output | 1 | Short frame with FCS error |
| jabberStrb | output | 1 | Oversized frame with FCS error |
| crcLegalStrb | output | 1 | Frame of at least 64 bytes with FCS error |
| runtStrb | output | 1 | Frame of 9 to 63 bytes |
| dataOkStrb | output | 3 | Good data frame, per cast |
| dataErrStrb | output | 3 | Errored data frame, per cast |
| ctrlOkStrb | output | 3 | Good control frame, per cast |
| ctrlErrStrb | output | 3 | Errored control frame, per cast |
| pauseStrb | output | 1 | Any pause frame |
| pauseErrStrb | output | 1 | Pause frame with FCS error |
| pfcOkStrb | output | 1 | Good PFC frame |
| pfcErrStrb | output | 1 | PFC frame with FCS error |

## Verification
Directed frames step through the length on both sides of every bucket edge: 8/9, 63/64/65, 127/128, 255/256, 511/512, 1023/1024, 1518/1519, and `maxLen` and `maxLen`+1. These cases separate off-by-one errors in the comparators, the runt floor and the fragment/legal-length split. Repeating the edges with `maxLen` at 1200, 1536 and 2000 shows whether the oversize decision tracks the programmed limit or a fixed bound, including the case where the limit cuts into the 1024–1518 bucket. Random frames mix every cast type, the control, pause and PFC flags, FCS errors, start events and idle cycles. They expose strobes that leak across cast bits or between the data and control counters, and strobes that fire without an event.

// File: rtl/rx_cls_pkg.sv
package rx_cls_pkg;

  localparam int NUM_BKT  = 7;
  localparam int NUM_CAST = 3;

  typedef enum logic [1:0] {
    CAST_UNI   = 2'd0,
    CAST_MULTI = 2'd1,
    CAST_BROAD = 2'd2,
    CAST_NONE  = 2'd3
  } cast_e;

  // Length decisions handed from the comparator datapath to the control
  typedef struct packed {
    logic               belowMin;
    logic               runtLen;
    logic               overMax;
    logic [NUM_BKT-1:0] bucket;
  } len_info_t;

  // Registered strobes for one frame
  typedef struct packed {
    logic                start;
    logic [NUM_BKT-1:0]  size;
    logic                oversize;
    logic                frag;
    logic                jabber;
    logic                crcLegal;
    logic                runt;
    logic [NUM_CAST-1:0] dataOk;
    logic [NUM_CAST-1:0] dataErr;
    logic [NUM_CAST-1:0] ctrlOk;
    logic [NUM_CAST-1:0] ctrlErr;
    logic                pause;
    logic                pauseErr;
    logic                pfcOk;
    logic                pfcErr;
  } stb_t;

  // Inclusive upper edge of fixed bucket idx (0 .. NUM_BKT-2)
  function automatic int bucketTop(int idx, int minLen, int stdMax);
    if (idx == 0)                return minLen;
    else if (idx == NUM_BKT - 2) return stdMax;
    else                         return (minLen << idx) - 1;
  endfunction

endpackage

// File: rtl/rx_cls_lenpath.sv
module rx_cls_lenpath
  import rx_cls_pkg::*;
#(
  parameter int LEN_W    = 14,
  parameter int MIN_LEN  = 64,
  parameter int RUNT_MAX = 8,
  parameter int STD_MAX  = 1518
) (
  input  logic [LEN_W-1:0] frameLen,
  input  logic [LEN_W-1:0] maxLen,
  output len_info_t        info
);

  localparam logic [LEN_W-1:0] MIN_V  = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] RUNT_V = LEN_W'(RUNT_MAX);
  localparam logic [LEN_W-1:0] STD_V  = LEN_W'(STD_MAX);

  logic overMax;
  logic [NUM_BKT-1:0] bucketHit;

  assign overMax = frameLen > maxLen;

  genvar i;
  generate
    for (i = 0; i < NUM_BKT; i++) begin : g_bkt
      if (i == NUM_BKT - 1) begin : g_top
        assign bucketHit[i] = (frameLen > STD_V) && !overMax;
      end else begin : g_fixed
        localparam logic [LEN_W-1:0] HI = LEN_W'(bucketTop(i, MIN_LEN, STD_MAX));
        localparam logic [LEN_W-1:0] LO = (i == 0) ? LEN_W'(MIN_LEN - 1)
                                                   : LEN_W'(bucketTop(i - 1, MIN_LEN, STD_MAX));
        assign bucketHit[i] = (frameLen > LO) && (frameLen <= HI) && !overMax;
      end
    end
  endgenerate

  always_comb begin
    info.belowMin = frameLen < MIN_V;
    info.runtLen  = (frameLen > RUNT_V) && (frameLen < MIN_V);
    info.overMax  = overMax;
    info.bucket   = bucketHit;
  end

endmodule

// File: rtl/rx_cls_ctrl.sv
module rx_cls_ctrl
  import rx_cls_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sofValid,
  input  logic       eofValid,
  input  logic       fcsErr,
  input  logic [1:0] castType,
  input  logic       isCtrl,
  input  logic       isPause,
  input  logic       isPfc,
  input  len_info_t  info,
  output stb_t       stbQ
);

  logic [NUM_CAST-1:0] castHot;
  stb_t                stbNext;

  genvar c;
  generate
    for (c = 0; c < NUM_CAST; c++) begin : g_cast
      assign castHot[c] = (castType == 2'(c));
    end
  endgenerate

  always_comb begin
    stbNext       = '0;
    stbNext.start = sofValid;
    if (eofValid) begin
      stbNext.size     = info.bucket;
      stbNext.oversize = info.overMax;
      stbNext.frag     = info.belowMin && fcsErr;
      stbNext.jabber   = info.overMax && fcsErr;
      stbNext.crcLegal = !info.belowMin && fcsErr;
      stbNext.runt     = info.runtLen;
      stbNext.dataOk   = (!isCtrl && !fcsErr) ? castHot : '0;
      stbNext.dataErr  = (!isCtrl &&  fcsErr) ? castHot : '0;
      stbNext.ctrlOk   = ( isCtrl && !fcsErr) ? castHot : '0;
      stbNext.ctrlErr  = ( isCtrl &&  fcsErr) ? castHot : '0;
      stbNext.pause    = isPause;
      stbNext.pauseErr = isPause && fcsErr;
      stbNext.pfcOk    = isPfc && !fcsErr;
      stbNext.pfcErr   = isPfc && fcsErr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stbQ <= '0;
    else       stbQ <= stbNext;
  end

endmodule

// File: rtl/rx_frame_classifier.sv
module rx_frame_classifier
  import rx_cls_pkg::*;
#(
  parameter int LEN_W    = 14,
  parameter int MIN_LEN  = 64,
  parameter int RUNT_MAX = 8,
  parameter int STD_MAX  = 1518
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sofValid,
  input  logic             eofValid,
  input  logic [LEN_W-1:0] frameLen,
  input  logic             fcsErr,
  input  logic [LEN_W-1:0] maxLen,
  input  logic [1:0]       castType,
  input  logic             isCtrl,
  input  logic             isPause,
  input  logic             isPfc,
  output logic             startStrb,
  output logic [6:0]       sizeStrb,
  output logic             oversizeStrb,
  output logic             fragStrb,
  output logic             jabberStrb,
  output logic             crcLegalStrb,
  output logic             runtStrb,
  output logic [2:0]       dataOkStrb,
  output logic [2:0]       dataErrStrb,
  output logic [2:0]       ctrlOkStrb,
  output logic [2:0]       ctrlErrStrb,
  output logic             pauseStrb,
  output logic             pauseErrStrb,
  output logic             pfcOkStrb,
  output logic             pfcErrStrb
);

  len_info_t lenInfo;
  stb_t      stb;

  rx_cls_lenpath #(
    .LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .RUNT_MAX(RUNT_MAX), .STD_MAX(STD_MAX)
  ) i_lenpath (
    .frameLen(frameLen),
    .maxLen  (maxLen),
    .info    (lenInfo)
  );

  rx_cls_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sofValid(sofValid),
    .eofValid(eofValid),
    .fcsErr  (fcsErr),
    .castType(castType),
    .isCtrl  (isCtrl),
    .isPause (isPause),
    .isPfc   (isPfc),
    .info    (lenInfo),
    .stbQ    (stb)
  );

  assign startStrb    = stb.start;
  assign sizeStrb     = stb.size;
  assign oversizeStrb = stb.oversize;
  assign fragStrb     = stb.frag;
  assign jabberStrb   = stb.jabber;
  assign crcLegalStrb = stb.crcLegal;
  assign runtStrb     = stb.runt;
  assign dataOkStrb   = stb.dataOk;
  assign dataErrStrb  = stb.dataErr;
  assign ctrlOkStrb   = stb.ctrlOk;
  assign ctrlErrStrb  = stb.ctrlErr;
  assign pauseStrb    = stb.pause;
  assign pauseErrStrb = stb.pauseErr;
  assign pfcOkStrb    = stb.pfcOk;
  assign pfcErrStrb   = stb.pfcErr;

endmodule

// File: rtl/rx_cls_chk.sv
module rx_cls_chk #(
  parameter int LEN_W = 14
) (
  input logic             clk,
  input logic             rstN,
  input logic             sofValid,
  input logic             eofValid,
  input logic [LEN_W-1:0] frameLen,
  input logic             fcsErr,
  input logic [LEN_W-1:0] maxLen,
  input logic [1:0]       castType,
  input logic             isCtrl,
  input logic             isPause,
  input logic             isPfc,
  input logic             startStrb,
  input logic [6:0]       sizeStrb,
  input logic             oversizeStrb,
  input logic             fragStrb,
  input logic             jabberStrb,
  input logic             crcLegalStrb,
  input logic             runtStrb,
  input logic [2:0]       dataOkStrb,
  input logic [2:0]       dataErrStrb,
  input logic [2:0]       ctrlOkStrb,
  input logic [2:0]       ctrlErrStrb,
  input logic             pauseStrb,
  input logic             pauseErrStrb,
  input logic             pfcOkStrb,
  input logic             pfcErrStrb
);

  logic anyFrameStrb;
  assign anyFrameStrb = (|sizeStrb) | oversizeStrb | fragStrb | jabberStrb | crcLegalStrb |
                        runtStrb | (|dataOkStrb) | (|dataErrStrb) | (|ctrlOkStrb) |
                        (|ctrlErrStrb) | pauseStrb | pauseErrStrb | pfcOkStrb | pfcErrStrb;

  // R1
  start_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    startStrb == $past(sofValid));

  // R2
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyFrameStrb |-> $past(eofValid));

  // R3
  bucket_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(sizeStrb));

  // R4
  over_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    oversizeStrb |-> (sizeStrb == 7'd0));

  // R5
  frag_short_chk: assert property (@(posedge clk) disable iff (!rstN)
    fragStrb |-> ($past(fcsErr) && !crcLegalStrb && (sizeStrb == 7'd0)));

  // R6
  jabber_over_chk: assert property (@(posedge clk) disable iff (!rstN)
    jabberStrb |-> (oversizeStrb && $past(fcsErr)));

  // R8
  runt_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    runtStrb |-> (($past(frameLen) > LEN_W'(8)) && ($past(frameLen) < LEN_W'(64))));

  // R9
  cast_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dataOkStrb, dataErrStrb, ctrlOkStrb, ctrlErrStrb}));

  // R11
  pause_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    pauseErrStrb |-> pauseStrb);

endmodule

bind rx_frame_classifier rx_cls_chk #(.LEN_W(LEN_W)) i_chk (.*);

// File: tb/test_rx_frame_classifier.sv
`timescale 1ns/1ps
module test_rx_frame_classifier;

  localparam int LEN_W = 14;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0;
  logic sofValid = 1'b0, eofValid = 1'b0, fcsErr = 1'b0;
  logic [LEN_W-1:0] frameLen = '0, maxLen = LEN_W'(1536);
  logic [1:0] castType = 2'd0;
  logic isCtrl = 1'b0, isPause = 1'b0, isPfc = 1'b0;

  logic startStrb, oversizeStrb, fragStrb, jabberStrb, crcLegalStrb, runtStrb;
  logic [6:0] sizeStrb;
  logic [2:0] dataOkStrb, dataErrStrb, ctrlOkStrb, ctrlErrStrb;
  logic pauseStrb, pauseErrStrb, pfcOkStrb, pfcErrStrb;

  rx_frame_classifier #(.LEN_W(LEN_W)) i_rx_frame_classifier (.*);

  int checks = 0;
  int errors = 0;

  // expected values for the frame currently in flight
  logic eStart, eOver, eFrag, eJab, eCrc, eRunt, ePause, ePauseErr, ePfcOk, ePfcErr;
  logic [6:0] eSize;
  logic [2:0] eDataOk, eDataErr, eCtrlOk, eCtrlErr;

  task automatic chk(string req, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic logic [6:0] bucketOf(int len, int mx);
    if (len > mx || len < 64) return 7'd0;
    if (len == 64)   return 7'd1;
    if (len <= 127)  return 7'd2;
    if (len <= 255)  return 7'd4;
    if (len <= 511)  return 7'd8;
    if (len <= 1023) return 7'd16;
    if (len <= 1518) return 7'd32;
    return 7'd64;
  endfunction

  task automatic clearExp();
    eStart = 0; eOver = 0; eFrag = 0; eJab = 0; eCrc = 0; eRunt = 0;
    ePause = 0; ePauseErr = 0; ePfcOk = 0; ePfcErr = 0;
    eSize = 0; eDataOk = 0; eDataErr = 0; eCtrlOk = 0; eCtrlErr = 0;
  endtask

  task automatic predict();
    int len = int'(frameLen);
    int mx  = int'(maxLen);
    logic [2:0] hot;
    clearExp();
    eStart = sofValid;
    if (eofValid) begin
      hot       = (castType == 2'd3) ? 3'b000 : 3'(1 << castType);
      eSize     = bucketOf(len, mx);
      eOver     = len > mx;
      eFrag     = (len < 64) && fcsErr;
      eJab      = (len > mx) && fcsErr;
      eCrc      = (len >= 64) && fcsErr;
      eRunt     = (len > 8) && (len < 64);
      eDataOk   = (!isCtrl && !fcsErr) ? hot : 3'b000;
      eDataErr  = (!isCtrl &&  fcsErr) ? hot : 3'b000;
      eCtrlOk   = ( isCtrl && !fcsErr) ? hot : 3'b000;
      eCtrlErr  = ( isCtrl &&  fcsErr) ? hot : 3'b000;
      ePause    = isPause;
      ePauseErr = isPause && fcsErr;
      ePfcOk    = isPfc && !fcsErr;
      ePfcErr   = isPfc && fcsErr;
    end
  endtask

  task automatic compare();
    chk("R1",  "startStrb",    startStrb,    eStart);
    chk("R3",  "sizeStrb",     sizeStrb,     eSize);
    chk("R4",  "oversizeStrb", oversizeStrb, eOver);
    chk("R5",  "fragStrb",     fragStrb,     eFrag);
    chk("R6",  "jabberStrb",   jabberStrb,   eJab);
    chk("R7",  "crcLegalStrb", crcLegalStrb, eCrc);
    chk("R8",  "runtStrb",     runtStrb,     eRunt);
    chk("R9",  "dataOkStrb",   dataOkStrb,   eDataOk);
    chk("R9",  "dataErrStrb",  dataErrStrb,  eDataErr);
    chk("R10", "ctrlOkStrb",   ctrlOkStrb,   eCtrlOk);
    chk("R10", "ctrlErrStrb",  ctrlErrStrb,  eCtrlErr);
    chk("R11", "pauseStrb",    pauseStrb,    ePause);
    chk("R11", "pauseErrStrb", pauseErrStrb, ePauseErr);
    chk("R12", "pfcOkStrb",    pfcOkStrb,    ePfcOk);
    chk("R12", "pfcErrStrb",   pfcErrStrb,   ePfcErr);
  endtask

  // One cycle: check the result of the previous drive, then apply new inputs
  task automatic drive(logic sof, logic eof, int len, logic fcs, int mx,
                       logic [1:0] cast, logic ctl, logic pse, logic pfc);
    @(negedge clk);
    compare();
    sofValid = sof; eofValid = eof; frameLen = LEN_W'(len); fcsErr = fcs;
    maxLen = LEN_W'(mx); castType = cast; isCtrl = ctl; isPause = pse; isPfc = pfc;
    predict();
  endtask

  task automatic frame(int len, logic fcs, int mx, logic [1:0] cast);
    drive(1'b0, 1'b1, len, fcs, mx, cast, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic finish();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(900_000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish();
  end

  initial begin
    int edges[18] = '{0, 8, 9, 63, 64, 65, 127, 128, 255, 256,
                      511, 512, 1023, 1024, 1518, 1519, 1536, 1537};
    int maxes[4]  = '{1200, 1518, 1536, 2000};
    void'($urandom(32'h5EED_0042));
    clearExp();
    repeat (3) @(negedge clk);
    // R2: all strobes low out of reset
    compare();
    rstN = 1'b1;

    // R3 R4 R5 R7 R8: length edges, good and bad FCS
    foreach (edges[k]) begin
      frame(edges[k], 1'b0, 1536, 2'd0);
      frame(edges[k], 1'b1, 1536, 2'd1);
    end
    // R4 R6: programmable limit, including one below the standard maximum
    frame(1200, 1'b0, 1200, 2'd2);
    frame(1201, 1'b1, 1200, 2'd2);
    frame(1519, 1'b0, 1200, 2'd0);
    frame(2000, 1'b0, 2000, 2'd0);
    frame(2001, 1'b1, 2000, 2'd1);
    // R9 R10: every cast, data and control
    for (int c = 0; c < 4; c++) begin
      drive(1'b0, 1'b1, 100, 1'b0, 1536, 2'(c), 1'b0, 1'b0, 1'b0);
      drive(1'b0, 1'b1, 100, 1'b1, 1536, 2'(c), 1'b0, 1'b0, 1'b0);
      drive(1'b0, 1'b1, 64,  1'b0, 1536, 2'(c), 1'b1, 1'b0, 1'b0);
      drive(1'b0, 1'b1, 64,  1'b1, 1536, 2'(c), 1'b1, 1'b0, 1'b0);
    end
    // R11 R12: pause and PFC with both FCS states
    drive(1'b0, 1'b1, 64, 1'b0, 1536, 2'd1, 1'b1, 1'b1, 1'b0);
    drive(1'b0, 1'b1, 64, 1'b1, 1536, 2'd1, 1'b1, 1'b1, 1'b0);
    drive(1'b0, 1'b1, 64, 1'b0, 1536, 2'd1, 1'b1, 1'b0, 1'b1);
    drive(1'b0, 1'b1, 64, 1'b1, 1536, 2'd1, 1'b1, 1'b0, 1'b1);
    // R1 R2: start with no end event, idle cycles with frame flags set
    drive(1'b1, 1'b0, 300, 1'b1, 1536, 2'd0, 1'b1, 1'b1, 1'b1);
    drive(1'b0, 1'b0, 30,  1'b1, 1536, 2'd2, 1'b0, 1'b1, 1'b1);
    drive(1'b1, 1'b1, 30,  1'b1, 1536, 2'd2, 1'b0, 1'b0, 1'b0);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      drive(1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 4) != 0),
            int'($urandom_range(0, 2200)), 1'($urandom_range(0, 2) == 0),
            maxes[$urandom_range(0, 3)], 2'($urandom_range(0, 3)),
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0),
            1'($urandom_range(0, 3) == 0));
    end
    drive(1'b0, 1'b0, 0, 1'b0, 1536, 2'd0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    compare();
    finish();
  end

endmodule